// File: doc/BRIEF.md
# Dual-Rail AMI Line Encoder with Bipolar Violation Insertion

This block turns a single-rail transmit bit stream into alternate mark inversion (AMI) pulses on two rails. A one bit is a mark: it comes out as a pulse on the positive rail or the negative rail, and each mark takes the polarity opposite to the mark before it. A zero bit is a space and leaves both rails idle. A rising edge on the violation-request pin arms one forced bipolar violation. The encoder places that violation on the next mark by repeating the polarity of the previous mark.

The mode inputs decide whether a violation may be inserted. Insertion works only when the single-rail AMI enable is set. When transmit-all-ones is combined with analog, remote or inband loopback, requests are discarded. When transmit-all-ones is combined with digital loopback, the line stays all ones with no violation, and the sampled request is returned toward the system side on a separate output. The loopback data paths themselves sit outside this block.

Top module: `ami_viol_enc`

## Requirements
- R1: Each mark is sent with the polarity opposite to the previous mark. The first mark after reset is positive.
- R2: A space (zero bit, transmit-all-ones off) drives neither rail. The two rails are never high together. A bit given in one cycle appears on the rails after the next rising clock edge.
- R3: The request pin is sampled on the falling clock edge. A low-to-high change of the sampled value arms exactly one violation. Holding the pin high arms nothing more.
- R4: An armed violation goes on the next mark, or on the mark in the same cycle as the edge, and has the same polarity as the previous mark. Spaces in between stay idle.
- R5: After a violation, alternation continues from the polarity of the violating pulse.
- R6: A second request edge that arrives while a violation is still armed merges with it. Only one violation results.
- R7: When the AMI enable is low, request edges are discarded and are not kept for later.
- R8: With transmit-all-ones set, every bit is a mark whatever the data input. Violations are still inserted when no loopback is selected.
- R9: Loopback select encoding: 0 none, 1 analog, 2 remote, 3 inband, 4 digital; codes 5 to 7 act as none. With transmit-all-ones and select 1, 2 or 3, requests and any armed violation are discarded.
- R10: With transmit-all-ones and select 4, the loopback output follows the sampled request one rising edge later, and the line carries no violation. In every other mode the loopback output is low.
- R11: Asynchronous active-low reset drives both rails and the loopback output low and clears any armed violation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| txClk | input | 1 | Transmit clock |
| rstN | input | 1 | Asynchronous active-low reset |
| txData | input | 1 | Single-rail transmit bit |
| vioReq | input | 1 | Violation request, sampled on the falling clock edge |
| amiEn | input | 1 | Single-rail AMI enable; required for insertion |
| allOnes | input | 1 | Transmit-all-ones mode |
| loopSel | input | 3 | Loopback select (0 none, 1 analog, 2 remote, 3 inband, 4 digital) |
| posRail | output | 1 | Positive pulse rail |
| negRail | output | 1 | Negative pulse rail |
| violLoop | output | 1 | Request looped back to the system side |

## Verification
The hardest state to reach is an armed violation that is still waiting when something else happens to it: a second edge arriving, a gating mode starting, or a reset. The stimulus raises the request during runs of spaces, so that the violation stays pending for several cycles. It then applies the merging edge, the mode change or the reset, and only after that sends a mark. The polarity of that mark shows whether the armed state was kept or cleared.

// File: rtl/ami_viol_pkg.sv
package ami_viol_pkg;

  localparam int LOOP_W = 3;

  typedef enum logic [LOOP_W-1:0] {
    LOOP_NONE    = 3'd0,
    LOOP_ANALOG  = 3'd1,
    LOOP_REMOTE  = 3'd2,
    LOOP_INBAND  = 3'd3,
    LOOP_DIGITAL = 3'd4
  } loopMode_e;

  // strobes from control to datapath, one set per bit period
  typedef struct packed {
    logic mark;     // current bit is a pulse
    logic violate;  // repeat previous polarity
  } encStrobe_t;

endpackage

// File: rtl/ami_viol_ctrl.sv
module ami_viol_ctrl
  import ami_viol_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       txData,
  input  logic       vioReq,
  input  logic       amiEn,
  input  logic       allOnes,
  input  loopMode_e  loopSel,
  output encStrobe_t strobe,
  output logic       violLoop
);

  logic reqSmp;
  logic reqPrev;
  logic pending;
  logic reqEdge;
  logic lineLoop;
  logic digLoop;
  logic inhibit;
  logic mark;
  logic wantViol;
  logic pendNext;

  // request pin captured on the falling edge of the transmit clock
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) reqSmp <= 1'b0;
    else       reqSmp <= vioReq;
  end

  always_comb begin
    reqEdge  = reqSmp && !reqPrev;
    lineLoop = allOnes && ((loopSel == LOOP_ANALOG) ||
                           (loopSel == LOOP_REMOTE) ||
                           (loopSel == LOOP_INBAND));
    digLoop  = allOnes && (loopSel == LOOP_DIGITAL);
    inhibit  = !amiEn || lineLoop || digLoop;
    mark     = allOnes || txData;
    wantViol = pending || reqEdge;

    strobe.mark    = mark;
    strobe.violate = !inhibit && wantViol && mark;

    if (inhibit)                pendNext = 1'b0;
    else if (wantViol && mark)  pendNext = 1'b0;
    else                        pendNext = wantViol;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqPrev  <= 1'b0;
      pending  <= 1'b0;
      violLoop <= 1'b0;
    end else begin
      reqPrev  <= reqSmp;
      pending  <= pendNext;
      violLoop <= digLoop && reqSmp;
    end
  end

endmodule

// File: rtl/ami_line_dp.sv
module ami_line_dp
  import ami_viol_pkg::*;
#(
  parameter bit FIRST_MARK_POS = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  encStrobe_t strobe,
  output logic       posRail,
  output logic       negRail
);

  logic lastPos;
  logic pulsePos;

  always_comb begin
    pulsePos = strobe.violate ? lastPos : !lastPos;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastPos <= !FIRST_MARK_POS;
      posRail <= 1'b0;
      negRail <= 1'b0;
    end else if (strobe.mark) begin
      lastPos <= pulsePos;
      posRail <= pulsePos;
      negRail <= !pulsePos;
    end else begin
      posRail <= 1'b0;
      negRail <= 1'b0;
    end
  end

endmodule

// File: rtl/ami_viol_enc.sv
module ami_viol_enc
  import ami_viol_pkg::*;
#(
  parameter bit FIRST_MARK_POS = 1'b1
) (
  input  logic              txClk,
  input  logic              rstN,
  input  logic              txData,
  input  logic              vioReq,
  input  logic              amiEn,
  input  logic              allOnes,
  input  logic [LOOP_W-1:0] loopSel,
  output logic              posRail,
  output logic              negRail,
  output logic              violLoop
);

  encStrobe_t strobe;

  ami_viol_ctrl u_ctrl (
    .clk      (txClk),
    .rstN     (rstN),
    .txData   (txData),
    .vioReq   (vioReq),
    .amiEn    (amiEn),
    .allOnes  (allOnes),
    .loopSel  (loopMode_e'(loopSel)),
    .strobe   (strobe),
    .violLoop (violLoop)
  );

  ami_line_dp #(.FIRST_MARK_POS(FIRST_MARK_POS)) u_dp (
    .clk     (txClk),
    .rstN    (rstN),
    .strobe  (strobe),
    .posRail (posRail),
    .negRail (negRail)
  );

endmodule

// File: rtl/ami_viol_chk.sv
module ami_viol_chk (
  input logic       txClk,
  input logic       rstN,
  input logic       txData,
  input logic       amiEn,
  input logic       allOnes,
  input logic [2:0] loopSel,
  input logic       posRail,
  input logic       negRail,
  input logic       violLoop
);

  // polarity of the most recent pulse seen on the rails (0 = negative)
  logic lastMarkPos;

  always_ff @(posedge txClk or negedge rstN) begin
    if (!rstN)        lastMarkPos <= 1'b0;
    else if (posRail) lastMarkPos <= 1'b1;
    else if (negRail) lastMarkPos <= 1'b0;
  end

  p_rails_excl_r2: assert property (@(posedge txClk) disable iff (!rstN)
    !(posRail && negRail));

  p_space_idle_r2: assert property (@(posedge txClk) disable iff (!rstN)
    (!txData && !allOnes) |=> (!posRail && !negRail));

  p_all_marks_r8: assert property (@(posedge txClk) disable iff (!rstN)
    allOnes |=> (posRail || negRail));

  p_no_viol_disabled_r7: assert property (@(posedge txClk) disable iff (!rstN)
    ((posRail || negRail) && $past(!amiEn)) |-> (posRail != lastMarkPos));

  p_no_viol_lineloop_r9: assert property (@(posedge txClk) disable iff (!rstN)
    ((posRail || negRail) &&
     $past(allOnes && (loopSel == 3'd1 || loopSel == 3'd2 || loopSel == 3'd3)))
    |-> (posRail != lastMarkPos));

  p_loop_mode_only_r10: assert property (@(posedge txClk) disable iff (!rstN)
    violLoop |-> $past(allOnes && loopSel == 3'd4));

  p_no_viol_digloop_r10: assert property (@(posedge txClk) disable iff (!rstN)
    ((posRail || negRail) && $past(allOnes && loopSel == 3'd4))
    |-> (posRail != lastMarkPos));

endmodule

bind ami_viol_enc ami_viol_chk u_chk (
  .txClk    (txClk),
  .rstN     (rstN),
  .txData   (txData),
  .amiEn    (amiEn),
  .allOnes  (allOnes),
  .loopSel  (loopSel),
  .posRail  (posRail),
  .negRail  (negRail),
  .violLoop (violLoop)
);

// File: tb/ami_viol_enc_tb.sv
module ami_viol_enc_tb;

  logic       txClk = 1'b0;
  logic       rstN = 1'b0;
  logic       txData = 1'b0;
  logic       vioReq = 1'b0;
  logic       amiEn = 1'b1;
  logic       allOnes = 1'b0;
  logic [2:0] loopSel = 3'd0;
  logic       posRail;
  logic       negRail;
  logic       violLoop;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #4 txClk = ~txClk;

  ami_viol_enc u_dut (
    .txClk    (txClk),
    .rstN     (rstN),
    .txData   (txData),
    .vioReq   (vioReq),
    .amiEn    (amiEn),
    .allOnes  (allOnes),
    .loopSel  (loopSel),
    .posRail  (posRail),
    .negRail  (negRail),
    .violLoop (violLoop)
  );

  // {data, request, expected positive, expected negative}
  // R1 alternation, R3 one violation per edge, R4 next mark,
  // R5 resume from violated polarity, R6 merged edges
  localparam logic [3:0] VEC [17] = '{
    4'b1010, 4'b0000, 4'b1001, 4'b1010, 4'b0100, 4'b0100,
    4'b1110, 4'b1101, 4'b1010, 4'b1110, 4'b0000, 4'b0100,
    4'b0000, 4'b0100, 4'b1010, 4'b1001, 4'b1010
  };

  task automatic check(input logic act, input logic exp, input string what, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic checkAll(input logic eP, input logic eN, input logic eL, input string tag);
    check(posRail, eP, "posRail", tag);
    check(negRail, eN, "negRail", tag);
    check(violLoop, eL, "violLoop", tag);
  endtask

  // inputs are driven 1 ns after a rising edge; the result is read 1 ns after the next one
  task automatic step(input logic d, input logic r, input logic eP, input logic eN,
                      input logic eL, input string tag);
    txData = d;
    vioReq = r;
    @(posedge txClk);
    #1;
    checkAll(eP, eN, eL, tag);
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge txClk);
    #1;
    checkAll(1'b0, 1'b0, 1'b0, "R11 reset");
    rstN = 1'b1;

    for (int i = 0; i < 17; i++) begin
      step(VEC[i][3], VEC[i][2], VEC[i][1], VEC[i][0], 1'b0, "R1/R3/R4/R5/R6 table");
    end
    // last mark positive

    // R7: edge while disabled is discarded
    amiEn = 1'b0;
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R7");
    step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R7");
    amiEn = 1'b1;
    step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R7");
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R2");

    // R8: all ones, no loopback, violation still allowed
    allOnes = 1'b1;
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R8");
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R8");
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R8");
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R8");

    // R9: line loopbacks with all ones discard requests
    loopSel = 3'd1;
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R9 analog");
    step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R9 analog");
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R9 analog");
    loopSel = 3'd2;
    step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R9 remote");
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R9 remote");
    loopSel = 3'd3;
    step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R9 inband");
    allOnes = 1'b0;
    loopSel = 3'd0;
    step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R9 nothing kept");
    // armed violation cleared by gating mode
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R9 arm");
    allOnes = 1'b1;
    loopSel = 3'd1;
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R9 gated mark");
    allOnes = 1'b0;
    loopSel = 3'd0;
    step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R9 pending cleared");

    // R10: digital loopback with all ones
    allOnes = 1'b1;
    loopSel = 3'd4;
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R10");
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, "R10");
    step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R10");
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R10");
    allOnes = 1'b0;
    step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R10 no loop without all ones");
    loopSel = 3'd0;
    step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R5");

    // R11: reset clears armed violation and polarity
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R11 arm");
    vioReq = 1'b0;
    #2;
    rstN = 1'b0;
    #1;
    checkAll(1'b0, 1'b0, 1'b0, "R11 reset");
    @(posedge txClk);
    #1;
    rstN = 1'b1;
    step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R11 first mark positive");
    step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R11 no stale violation");

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule